// File: doc/BRIEF.md
# Byte Alignment Address and Data Unit

This unit lets a datapath fetch an 8-byte quantity that starts at any byte address, using only aligned 8-byte accesses. It offers two kinds of operation. The address operation adds two 64-bit operands, rounds the sum down to an 8-byte boundary and returns that rounded address. At the same time it stores the sum's byte position within the 8-byte word in a small 3-bit offset register. A second flavour of the address operation stores the negated position, for little-endian byte ordering.

The data operation takes two 64-bit words that hold two consecutive aligned loads. It treats them as one 16-byte string, with the first word holding the lower addresses. It returns the 8 bytes that begin at the stored offset. The normal sequence is one address operation, then two aligned loads, then one data operation. Both operations need one clock edge. The result and the offset are both registered outputs.

Top module: `bytealign_unit`

## Requirements
- R1: While `rst` is high, and at the first output after reset, both `result` and `byte_ofs` are zero.
- R2: With `op_sel` = 2'b01 (big-endian address) or 2'b10 (little-endian address), `result` becomes, after the next clock edge, the sum `opnd_a + opnd_b` modulo 2^64 with bits [2:0] cleared.
- R3: With `op_sel` = 2'b01, `byte_ofs` becomes `(opnd_a + opnd_b)[2:0]` after the next clock edge.
- R4: With `op_sel` = 2'b10, `byte_ofs` becomes the low 3 bits of `0 - (opnd_a + opnd_b)` after the next clock edge.
- R5: With `op_sel` = 2'b11 (data align), the 16-byte string S is {`opnd_a`, `opnd_b`}, whose byte 0 is `opnd_a[63:56]` and whose byte 15 is `opnd_b[7:0]`. After the next clock edge, `result` holds bytes `byte_ofs` through `byte_ofs`+7 of S, with the lowest-numbered byte in `result[63:56]`.
- R6: A data align with `byte_ofs` = 0 returns `opnd_a` exactly; `opnd_b` has no effect.
- R7: `byte_ofs` changes only on address operations. Data align and idle leave it unchanged.
- R8: With `op_sel` = 2'b00 (idle), `result` keeps its previous value.
- R9: A data align issued in the cycle right after an address operation uses the offset that the address operation just stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 2 | 00 idle, 01 big-endian address, 10 little-endian address, 11 data align |
| opnd_a | input | 64 | First operand; for data align, the word at the lower addresses |
| opnd_b | input | 64 | Second operand; for data align, the word at the higher addresses |
| result | output | 64 | Registered aligned address or extracted data |
| byte_ofs | output | 3 | Registered stored byte offset |

## Verification
If the stored offset is wrong, the error does not appear at an address operation. It appears at the next data align, where `result` shows a byte rotation that is off by the offset error. For that reason every address operation in the bench is followed by a data align, so that any error is caught within two cycles. If the funnel mishandles the top-offset or zero-offset edge, a byte from the wrong word leaks into `result`. The bench therefore sweeps all eight offsets with distinct byte patterns, so each leaked byte can be identified.

// File: rtl/ba_pkg.sv
`timescale 1ns/1ps
package ba_pkg;
  typedef enum logic [1:0] {
    BA_IDLE    = 2'b00,
    BA_ADDR_BE = 2'b01,
    BA_ADDR_LE = 2'b10,
    BA_DATA    = 2'b11
  } ba_op_e;
endpackage

// File: rtl/ba_addr_calc.sv
`timescale 1ns/1ps
module ba_addr_calc #(
  parameter int DATA_W = 64,
  parameter int OFS_W  = 3
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              little,
  output logic [DATA_W-1:0] aligned,
  output logic [OFS_W-1:0]  ofs_next
);
  logic [DATA_W-1:0] sum;
  logic [OFS_W-1:0]  neg_lo;

  always_comb begin
    sum     = a + b;
    aligned = {sum[DATA_W-1:OFS_W], {OFS_W{1'b0}}};
    // only the low bits of the two's complement are needed
    neg_lo  = OFS_W'(~sum[OFS_W-1:0]) + OFS_W'(1);
    ofs_next = little ? neg_lo : sum[OFS_W-1:0];
  end
endmodule

// File: rtl/ba_funnel.sv
`timescale 1ns/1ps
module ba_funnel #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0]                   hi_word,
  input  logic [DATA_W-1:0]                   lo_word,
  input  logic [$clog2(DATA_W/LANE_W)-1:0]    ofs,
  output logic [DATA_W-1:0]                   out
);
  localparam int NB    = DATA_W / LANE_W;
  localparam int OFS_W = $clog2(NB);
  localparam int CAT_W = 2 * DATA_W;

  logic [CAT_W-1:0]  cat;
  logic [LANE_W-1:0] lane [0:2*NB-1];

  assign cat = {hi_word, lo_word};

  // lane 0 is the most significant byte of the concatenation
  for (genvar s = 0; s < 2*NB; s++) begin : g_lane
    assign lane[s] = cat[CAT_W-1-s*LANE_W -: LANE_W];
  end

  for (genvar k = 0; k < NB; k++) begin : g_out
    logic [OFS_W:0] idx;
    assign idx = {1'b0, ofs} + (OFS_W+1)'(k);
    assign out[DATA_W-1-k*LANE_W -: LANE_W] = lane[idx];
  end
endmodule

// File: rtl/ba_offset_reg.sv
`timescale 1ns/1ps
module ba_offset_reg #(
  parameter int OFS_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [OFS_W-1:0] d,
  output logic [OFS_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/bytealign_unit.sv
`timescale 1ns/1ps
module bytealign_unit
  import ba_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8,
  localparam int NB    = DATA_W / LANE_W,
  localparam int OFS_W = $clog2(NB)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        op_sel,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic [DATA_W-1:0] result,
  output logic [OFS_W-1:0]  byte_ofs
);
  ba_op_e            op;
  logic              is_addr;
  logic [DATA_W-1:0] aligned;
  logic [OFS_W-1:0]  ofs_next;
  logic [DATA_W-1:0] funnel_out;

  assign op      = ba_op_e'(op_sel);
  assign is_addr = (op == BA_ADDR_BE) || (op == BA_ADDR_LE);

  ba_addr_calc #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_addr (
    .a(opnd_a), .b(opnd_b), .little(op == BA_ADDR_LE),
    .aligned(aligned), .ofs_next(ofs_next)
  );

  ba_offset_reg #(.OFS_W(OFS_W)) u_ofs (
    .clk(clk), .rst(rst), .load(is_addr), .d(ofs_next), .q(byte_ofs)
  );

  ba_funnel #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_fun (
    .hi_word(opnd_a), .lo_word(opnd_b), .ofs(byte_ofs), .out(funnel_out)
  );

  always_ff @(posedge clk) begin
    if (rst) result <= '0;
    else begin
      case (op)
        BA_ADDR_BE, BA_ADDR_LE: result <= aligned;
        BA_DATA:                result <= funnel_out;
        default:                result <= result;
      endcase
    end
  end

  // R7
  ofs_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(op_sel == 2'b01 || op_sel == 2'b10) |=> $stable(byte_ofs));

  // R2
  addr_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 2'b01 || op_sel == 2'b10) |=> result[OFS_W-1:0] == '0);

  // R3
  be_ofs_chk: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 2'b01) |=> byte_ofs == $past(opnd_a[OFS_W-1:0] + opnd_b[OFS_W-1:0]));

  // R6
  zero_ofs_chk: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 2'b11 && byte_ofs == '0) |=> result == $past(opnd_a));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 2'b00) |=> $stable(result));
endmodule

// File: tb/sim_bytealign_unit.sv
`timescale 1ns/1ps
module sim_bytealign_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  op_sel = 2'b00;
  logic [63:0] opnd_a = '0;
  logic [63:0] opnd_b = '0;
  logic [63:0] result;
  logic [2:0]  byte_ofs;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [63:0] res;
    logic [2:0]  ofs;
    string       tag;
  } exp_t;
  exp_t sb[$];

  logic [63:0] m_res = '0;
  logic [2:0]  m_ofs = '0;

  always #10 clk = ~clk;

  bytealign_unit u0 (
    .clk(clk), .rst(rst), .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .result(result), .byte_ofs(byte_ofs)
  );

  function automatic logic [63:0] model_extract(logic [63:0] a, logic [63:0] b, logic [2:0] o);
    logic [127:0] c;
    c = {a, b} << (8 * o);
    return c[127:64];
  endfunction

  task automatic do_op(input logic [1:0] op, input logic [63:0] a, input logic [63:0] b,
                       input string tag);
    logic [63:0] s;
    exp_t e;
    @(negedge clk);
    op_sel = op; opnd_a = a; opnd_b = b;
    s = a + b;
    case (op)
      2'b01: begin m_res = {s[63:3], 3'b000}; m_ofs = s[2:0]; end
      2'b10: begin m_res = {s[63:3], 3'b000}; m_ofs = 3'(64'd0 - s); end
      2'b11: m_res = model_extract(a, b, m_ofs);
      default: ;
    endcase
    e.res = m_res; e.ofs = m_ofs; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: compare one cycle after each driven operation
  always @(posedge clk) begin
    #2;
    if (sb.size() != 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (result !== e.res) begin
        errors++;
        $display("FAIL %s result got %h exp %h", e.tag, result, e.res);
      end
      checks++;
      if (byte_ofs !== e.ofs) begin
        errors++;
        $display("FAIL %s byte_ofs got %0d exp %0d", e.tag, byte_ofs, e.ofs);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  localparam logic [63:0] PAT_A = 64'h0011223344556677;
  localparam logic [63:0] PAT_B = 64'h8899AABBCCDDEEFF;

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if (result !== 64'd0 || byte_ofs !== 3'd0) begin
      errors++;
      $display("FAIL R1 reset got %h/%0d exp 0/0", result, byte_ofs);
    end
    rst = 1'b0;

    // R6 offset zero after reset: A only
    do_op(2'b11, PAT_A, PAT_B, "R6");
    do_op(2'b11, 64'hDEADBEEF01234567, 64'hFFFFFFFFFFFFFFFF, "R6");

    // R5 / R9 sweep of all offsets through the big-endian address path
    for (int o = 0; o < 8; o++) begin
      do_op(2'b01, 64'h1000, 64'(o), "R3");
      do_op(2'b11, PAT_A, PAT_B, "R5_R9");
    end

    // R2 carry across the alignment boundary and wrap modulo 2^64
    do_op(2'b01, 64'h0000_0000_0000_0FFD, 64'd6, "R2");
    do_op(2'b10, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, "R2_R4");
    do_op(2'b11, PAT_A, PAT_B, "R9");

    // R4 little-endian: all sums mod 8
    for (int o = 0; o < 8; o++) begin
      do_op(2'b10, 64'h2000, 64'(o), "R4");
      do_op(2'b11, PAT_B, PAT_A, "R5_R9");
    end

    // R7 data align and idle leave offset; R8 idle holds result
    do_op(2'b01, 64'd5, 64'd0, "R3");
    do_op(2'b11, PAT_A, PAT_B, "R7");
    do_op(2'b00, 64'hAAAA, 64'h5555, "R8");
    do_op(2'b00, 64'h1, 64'h2, "R8_R7");

    // random sums, both variants, each followed by a data align
    for (int i = 0; i < 20; i++) begin
      do_op(2'b01, {$urandom, $urandom}, {$urandom, $urandom}, "R2_R3");
      do_op(2'b11, {$urandom, $urandom}, {$urandom, $urandom}, "R5");
      do_op(2'b10, {$urandom, $urandom}, {$urandom, $urandom}, "R2_R4");
      do_op(2'b11, {$urandom, $urandom}, {$urandom, $urandom}, "R5");
    end

    do_op(2'b00, '0, '0, "R8");
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule